// File: doc/BRIEF.md
# Fragmenting Mailbox Transmit Engine

This block sends a byte message of any length to a peer through a slot-based mailbox. Each slot is 32 bits wide. The message is cut into fragments. Each fragment is one header slot followed by its payload slots. The fragment size is worked out at the start of every attempt from the buffer depth the mailbox advertises. Before writing, the engine waits until the peer is ready and until there are enough free slots. After each fragment it rings the peer with a one-cycle interrupt-generate pulse.

If the peer drops ready after a fragment, the attempt fails. It also fails if a wait runs past its timeout. A failed attempt starts the whole message again from its first byte, up to a fixed number of attempts.

The requester supplies the message length, the two 8-bit addresses and a one-cycle start pulse. The engine then fetches the message bytes through a combinational read port (`rdAddr` to `rdData`). A one-cycle `done` pulse with `ok` reports the outcome.

Top module: `frag_tx_engine`

## Requirements
- R1: Every header slot is laid out as follows: bit 31 is the complete flag; bits 30:25 are zero; bits 24:16 hold the fragment payload length in bytes; bits 15:8 hold `srcAddr`; bits 7:0 hold `dstAddr`.
- R2: When ready is seen at the start of each attempt, the engine sets the fragment payload limit to min(4·`cbDepth`, 511) − 4 bytes. Fragments take that many bytes, except the last, which takes the rest. A limit of zero (`cbDepth` < 2) fails the attempt with no write.
- R3: The complete flag is 1 only in the header of the fragment that carries the last byte of the message.
- R4: A header is written only after `emptySlots` ≥ 1 has been seen. A fragment's payload is written only after `emptySlots` ≥ ceil(length/4) has been seen.
- R5: Payload bytes are packed little-endian, so the first byte of a slot goes to bits 7:0. The unused bytes of a final partial slot are zero.
- R6: `intGen` pulses for one cycle directly after the last slot of each fragment. If `peerReady` is low in the following cycle, the attempt fails.
- R7: A start with `msgLen` = 0 gives `done` with `ok` = 0 in the next cycle. It produces no write, no `intClr` and no `intGen`.
- R8: `intClr` pulses exactly once per accepted message, in the cycle after the start edge. It does not pulse again on retries.
- R9: A failed attempt waits for ready again and resends the message from byte 0. After 5 failed attempts, `done` pulses with `ok` = 0.
- R10: Each wait samples its condition every `POLL_GAP` cycles, starting on entry. The wait gives up after `TIMEOUT_CYC` cycles.
- R11: A start pulse while a message is in progress is ignored.
- R12: `done` is a one-cycle pulse. `ok` is 1 with it only after every fragment has been sent and acknowledged by a high `peerReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to send a message |
| msgLen | input | LEN_W | Message length in bytes |
| srcAddr | input | 8 | Sending-side address placed in headers |
| dstAddr | input | 8 | Receiving-side address placed in headers |
| rdAddr | output | LEN_W | Byte index into the message |
| rdData | input | 8 | Message byte at `rdAddr`, same cycle |
| peerReady | input | 1 | Peer is ready to communicate |
| cbDepth | input | DEPTH_W | Advertised mailbox depth in slots |
| emptySlots | input | DEPTH_W | Free slots currently in the mailbox |
| wrValid | output | 1 | Slot write strobe |
| wrData | output | 32 | Slot written to the mailbox window |
| intGen | output | 1 | Doorbell pulse after each fragment |
| intClr | output | 1 | Clears the pending interrupt status before sending |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Outcome, valid with `done` |

## Verification
`intClr` is due one cycle after the start edge. A zero-length start yields `done` in the same following cycle. `intGen` comes in the cycle right after the last slot write of each fragment, and the peer-ready sample that decides success or retry lands one cycle after that. The bench keeps an ordered queue of expected slots built from the requirements and compares every write at the falling edge of the cycle in which `wrValid` is high. Wait behaviour is checked by holding `emptySlots` or `peerReady` low for a known number of cycles and counting writes and elapsed cycles, with margins no wider than one poll interval plus the fixed state overhead.

// File: rtl/frag_tx_pkg.sv
package frag_tx_pkg;
  localparam int HDR_LEN_W   = 9;
  localparam int HDR_LEN_MAX = 511;
  localparam int SLOT_BYTES  = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_RDY, S_SETUP, S_WHDR, S_HDR, S_WPAY, S_PAY, S_RING, S_CHK, S_END
  } txState_t;

  typedef struct packed {
    logic loadMsg;
    logic rewind;
    logic setupFrag;
    logic emitHdr;
    logic payStep;
    logic commitFrag;
  } txStb_t;
endpackage

// File: rtl/frag_tx_dp.sv
module frag_tx_dp
  import frag_tx_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int DEPTH_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  txStb_t             stb,
  input  logic [LEN_W-1:0]   msgLen,
  input  logic [7:0]         srcAddr,
  input  logic [7:0]         dstAddr,
  input  logic [DEPTH_W-1:0] cbDepth,
  input  logic [7:0]         rdData,
  output logic [LEN_W-1:0]   rdAddr,
  output logic [31:0]        wrData,
  output logic               wrSlot,
  output logic               fragLast,
  output logic               lastFrag,
  output logic               zeroPay,
  output logic [HDR_LEN_W-2:0] slotsNeed
);
  logic [LEN_W-1:0]     lenQ, offQ, remLen;
  logic [7:0]           srcQ, dstQ;
  logic [HDR_LEN_W-1:0] maxPayQ, fragLenQ, fragPosQ, maxPayN, fragLenN;
  logic [31:0]          bufQ, gathered, header;
  logic [1:0]           lane;
  logic                 slotEnd;

  always_comb begin
    int depthBytes, capBytes, remInt, maxInt;
    depthBytes = int'(cbDepth) * SLOT_BYTES;
    capBytes   = (depthBytes > HDR_LEN_MAX) ? HDR_LEN_MAX : depthBytes;
    maxPayN    = HDR_LEN_W'((capBytes >= SLOT_BYTES) ? capBytes - SLOT_BYTES : 0);
    remInt     = int'(remLen);
    maxInt     = int'(maxPayQ);
    fragLenN   = HDR_LEN_W'((remInt < maxInt) ? remInt : maxInt);
  end

  assign remLen    = lenQ - offQ;
  assign lastFrag  = int'(fragLenQ) == int'(remLen);
  assign zeroPay   = (maxPayQ == '0);
  assign slotsNeed = (HDR_LEN_W-1)'((int'(fragLenQ) + SLOT_BYTES - 1) / SLOT_BYTES);
  assign lane      = fragPosQ[1:0];
  assign fragLast  = (fragPosQ == fragLenQ - HDR_LEN_W'(1));
  assign slotEnd   = (lane == 2'd3) || fragLast;
  assign rdAddr    = offQ + LEN_W'(fragPosQ);
  assign gathered  = bufQ | (32'(rdData) << {lane, 3'b000});
  assign header    = {lastFrag, 6'b0, fragLenQ, srcQ, dstQ};
  assign wrData    = stb.emitHdr ? header : gathered;
  assign wrSlot    = stb.payStep && slotEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenQ <= '0; offQ <= '0; srcQ <= '0; dstQ <= '0;
      maxPayQ <= '0; fragLenQ <= '0; fragPosQ <= '0; bufQ <= '0;
    end else begin
      if (stb.loadMsg) begin
        lenQ <= msgLen; srcQ <= srcAddr; dstQ <= dstAddr;
      end
      if (stb.rewind) begin
        offQ    <= '0;
        maxPayQ <= maxPayN;
      end
      if (stb.setupFrag) begin
        fragLenQ <= fragLenN;
        fragPosQ <= '0;
        bufQ     <= '0;
      end
      if (stb.payStep) begin
        fragPosQ <= fragPosQ + HDR_LEN_W'(1);
        bufQ     <= slotEnd ? '0 : gathered;
      end
      if (stb.commitFrag) offQ <= offQ + LEN_W'(fragLenQ);
    end
  end
endmodule

// File: rtl/frag_tx_ctrl.sv
module frag_tx_ctrl
  import frag_tx_pkg::*;
#(
  parameter int DEPTH_W     = 8,
  parameter int TIMEOUT_CYC = 256,
  parameter int POLL_GAP    = 4,
  parameter int MAX_TRIES   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic               lenZero,
  input  logic               peerReady,
  input  logic [DEPTH_W-1:0] emptySlots,
  input  logic [HDR_LEN_W-2:0] slotsNeed,
  input  logic               fragLast,
  input  logic               lastFrag,
  input  logic               zeroPay,
  output txStb_t             stb,
  output logic               intGen,
  output logic               intClr,
  output logic               done,
  output logic               ok
);
  localparam int WAIT_W = $clog2(TIMEOUT_CYC + 1);
  localparam int POLL_W = $clog2(POLL_GAP + 1);
  localparam int TRY_W  = $clog2(MAX_TRIES + 1);

  txState_t          stateQ, stateN;
  logic [WAIT_W-1:0] waitQ;
  logic [POLL_W-1:0] pollQ;
  logic [TRY_W-1:0]  triesQ;
  logic inWait, condMet, pass, expire, failN, succ, restart;

  assign inWait = (stateQ == S_RDY) || (stateQ == S_WHDR) || (stateQ == S_WPAY);

  always_comb begin
    unique case (stateQ)
      S_RDY:   condMet = peerReady;
      S_WHDR:  condMet = (emptySlots != '0);
      S_WPAY:  condMet = int'(emptySlots) >= int'(slotsNeed);
      default: condMet = 1'b0;
    endcase
  end

  assign pass   = inWait && (pollQ == '0) && condMet;
  assign expire = inWait && !pass && (waitQ == WAIT_W'(TIMEOUT_CYC - 1));

  always_comb begin
    stateN = stateQ;
    stb    = '0;
    failN  = 1'b0;
    succ   = 1'b0;
    unique case (stateQ)
      S_IDLE: if (startPulse) begin
        stb.loadMsg = 1'b1;
        stateN = lenZero ? S_END : S_CLR;
      end
      S_CLR: stateN = S_RDY;
      S_RDY: begin
        if (pass) begin stb.rewind = 1'b1; stateN = S_SETUP; end
        else if (expire) failN = 1'b1;
      end
      S_SETUP: begin
        if (zeroPay) failN = 1'b1;
        else begin stb.setupFrag = 1'b1; stateN = S_WHDR; end
      end
      S_WHDR: begin
        if (pass) stateN = S_HDR;
        else if (expire) failN = 1'b1;
      end
      S_HDR: begin stb.emitHdr = 1'b1; stateN = S_WPAY; end
      S_WPAY: begin
        if (pass) stateN = S_PAY;
        else if (expire) failN = 1'b1;
      end
      S_PAY: begin
        stb.payStep = 1'b1;
        if (fragLast) stateN = S_RING;
      end
      S_RING: stateN = S_CHK;
      S_CHK: begin
        if (!peerReady) failN = 1'b1;
        else begin
          stb.commitFrag = 1'b1;
          if (lastFrag) begin succ = 1'b1; stateN = S_END; end
          else stateN = S_SETUP;
        end
      end
      S_END: stateN = S_IDLE;
      default: stateN = S_IDLE;
    endcase
    if (failN) stateN = (triesQ == TRY_W'(MAX_TRIES - 1)) ? S_END : S_RDY;
  end

  assign restart = (stateN != stateQ) || failN;
  assign intGen  = (stateQ == S_RING);
  assign intClr  = (stateQ == S_CLR);
  assign done    = (stateQ == S_END);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE; waitQ <= '0; pollQ <= '0; triesQ <= '0; ok <= 1'b0;
    end else begin
      stateQ <= stateN;
      if (restart) begin
        waitQ <= '0;
        pollQ <= '0;
      end else if (inWait) begin
        waitQ <= waitQ + WAIT_W'(1);
        pollQ <= (pollQ == '0) ? POLL_W'(POLL_GAP - 1) : pollQ - POLL_W'(1);
      end
      if (stateQ == S_IDLE && startPulse) triesQ <= '0;
      else if (failN) triesQ <= triesQ + TRY_W'(1);
      if (stateN == S_END && stateQ != S_END) ok <= succ;
    end
  end
endmodule

// File: rtl/frag_tx_engine.sv
module frag_tx_engine
  import frag_tx_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int DEPTH_W     = 8,
  parameter int TIMEOUT_CYC = 256,
  parameter int POLL_GAP    = 4,
  parameter int MAX_TRIES   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [LEN_W-1:0]   msgLen,
  input  logic [7:0]         srcAddr,
  input  logic [7:0]         dstAddr,
  output logic [LEN_W-1:0]   rdAddr,
  input  logic [7:0]         rdData,
  input  logic               peerReady,
  input  logic [DEPTH_W-1:0] cbDepth,
  input  logic [DEPTH_W-1:0] emptySlots,
  output logic               wrValid,
  output logic [31:0]        wrData,
  output logic               intGen,
  output logic               intClr,
  output logic               done,
  output logic               ok
);
  txStb_t ctrlStb;
  logic wrSlot, fragLast, lastFrag, zeroPay;
  logic [HDR_LEN_W-2:0] slotsNeed;

  frag_tx_ctrl #(
    .DEPTH_W(DEPTH_W), .TIMEOUT_CYC(TIMEOUT_CYC), .POLL_GAP(POLL_GAP), .MAX_TRIES(MAX_TRIES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .lenZero(msgLen == '0),
    .peerReady(peerReady), .emptySlots(emptySlots), .slotsNeed(slotsNeed),
    .fragLast(fragLast), .lastFrag(lastFrag), .zeroPay(zeroPay), .stb(ctrlStb),
    .intGen(intGen), .intClr(intClr), .done(done), .ok(ok)
  );

  frag_tx_dp #(.LEN_W(LEN_W), .DEPTH_W(DEPTH_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(ctrlStb), .msgLen(msgLen), .srcAddr(srcAddr),
    .dstAddr(dstAddr), .cbDepth(cbDepth), .rdData(rdData), .rdAddr(rdAddr),
    .wrData(wrData), .wrSlot(wrSlot), .fragLast(fragLast), .lastFrag(lastFrag),
    .zeroPay(zeroPay), .slotsNeed(slotsNeed)
  );

  assign wrValid = ctrlStb.emitHdr | wrSlot;
endmodule

// File: rtl/frag_tx_checker.sv
module frag_tx_checker #(
  parameter int DEPTH_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               startPulse,
  input logic [DEPTH_W-1:0] emptySlots,
  input logic               hdrStb,
  input logic               wrValid,
  input logic [31:0]        wrData,
  input logic               intGen,
  input logic               intClr,
  input logic               done
);
  AST_HDR_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    hdrStb |-> (wrValid && wrData[30:25] == 6'd0)); // R1
  AST_HDR_HAS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    hdrStb |-> ($past(emptySlots) != '0)); // R4
  AST_RING_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    intGen |-> ($past(wrValid) && !wrValid)); // R6
  AST_CLR_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    intClr |-> $past(startPulse)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R12
  AST_OUTPUTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrValid, intGen, intClr, done})); // R6
endmodule

bind frag_tx_engine frag_tx_checker #(.DEPTH_W(DEPTH_W)) u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .emptySlots(emptySlots),
  .hdrStb(ctrlStb.emitHdr), .wrValid(wrValid), .wrData(wrData), .intGen(intGen),
  .intClr(intClr), .done(done)
);

// File: tb/tb_frag_tx_engine.sv
`timescale 1ns/1ps
module tb_frag_tx_engine;
  localparam int TMO = 256;
  logic clk = 1'b0, rstN = 1'b0, startPulse = 1'b0, peerReady = 1'b1;
  logic [15:0] msgLen = '0, rdAddr;
  logic [7:0]  srcAddr = '0, dstAddr = '0, rdData, cbDepth = 8'd8, emptySlots = 8'd255;
  logic wrValid, intGen, intClr, done, ok;
  logic [31:0] wrData;
  logic [7:0] mem [0:1023];
  logic [31:0] expQ[$];
  int checks = 0, errors = 0, wrCnt = 0, genCnt = 0, clrCnt = 0;
  int lastCyc; logic lastOk;

  always #2.5 clk = ~clk;
  assign rdData = mem[rdAddr[9:0]];

  frag_tx_engine dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .msgLen(msgLen), .srcAddr(srcAddr),
    .dstAddr(dstAddr), .rdAddr(rdAddr), .rdData(rdData), .peerReady(peerReady),
    .cbDepth(cbDepth), .emptySlots(emptySlots), .wrValid(wrValid), .wrData(wrData),
    .intGen(intGen), .intClr(intClr), .done(done), .ok(ok)
  );

  task automatic chk(input logic cond, input string tag, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison of slot writes against the expected queue.
  always @(negedge clk) if (rstN) begin
    if (wrValid) begin
      wrCnt++;
      if (expQ.size() == 0) chk(1'b0, "R1/R5 unexpected write", longint'(wrData), 0);
      else begin
        automatic logic [31:0] e = expQ.pop_front();
        chk(wrData == e, "R1/R3/R5 slot", longint'(wrData), longint'(e));
      end
    end
    if (intGen) genCnt++;
    if (intClr) clrCnt++;
  end

  task automatic pushFrags(input int len, input int depth, input int src, input int dst, input int maxFrags);
    int cap, maxPay, off, n;
    cap = (depth * 4 > 511) ? 511 : depth * 4;
    maxPay = cap - 4; off = 0; n = 0;
    while (off < len) begin
      int f; logic last;
      f = (len - off < maxPay) ? len - off : maxPay;
      last = (off + f == len);
      expQ.push_back({last, 6'b0, 9'(f), 8'(src), 8'(dst)});
      for (int s = 0; s < (f + 3) / 4; s++) begin
        logic [31:0] w = '0;
        for (int b = 0; b < 4; b++)
          if (s * 4 + b < f) w[b*8 +: 8] = mem[off + s*4 + b];
        expQ.push_back(w);
      end
      off += f; n++;
      if (maxFrags != 0 && n == maxFrags) break;
    end
  endtask

  task automatic runMsg(input int len, input int depth, input int src, input int dst);
    msgLen = 16'(len); cbDepth = 8'(depth); srcAddr = 8'(src); dstAddr = 8'(dst);
    wrCnt = 0; genCnt = 0; clrCnt = 0;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    lastCyc = 0;
    while (!done && lastCyc < 20000) begin @(negedge clk); lastCyc++; end
    lastOk = ok;
    chk(expQ.size() == 0, "R12 all slots written", expQ.size(), 0);
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!wrValid && !intGen && !intClr && !done, "R12 reset quiet", {wrValid, intGen, intClr, done}, 0);

    // R7 zero-length rejected in the next cycle
    runMsg(0, 8, 1, 2);
    chk(lastCyc == 0, "R7 zero-length latency", lastCyc, 0);
    chk(lastOk == 1'b0, "R7 zero-length ok", lastOk, 0);
    chk(wrCnt == 0 && clrCnt == 0 && genCnt == 0, "R7 no activity", wrCnt + clrCnt + genCnt, 0);
    @(negedge clk);

    // R1 R5 short single-fragment message with padding
    pushFrags(5, 8, 8'h3C, 8'hA5, 0);
    runMsg(5, 8, 8'h3C, 8'hA5);
    chk(lastOk, "R12 short ok", lastOk, 1);
    chk(clrCnt == 1, "R8 clear once", clrCnt, 1);
    chk(genCnt == 1, "R6 one ring", genCnt, 1);
    @(negedge clk);

    // R2 R3 three fragments, 28/28/14; R11 start while busy ignored
    pushFrags(70, 8, 1, 2, 0);
    fork
      runMsg(70, 8, 1, 2);
      begin
        repeat (20) @(negedge clk);
        startPulse = 1'b1; msgLen = 16'd3;
        @(negedge clk);
        startPulse = 1'b0;
      end
    join
    chk(lastOk, "R2 multi ok", lastOk, 1);
    chk(genCnt == 3, "R6 ring per fragment", genCnt, 3);
    chk(clrCnt == 1, "R11 busy start ignored", clrCnt, 1);
    chk(wrCnt == 21, "R2 slot count", wrCnt, 21);
    @(negedge clk);

    // R2 length cap at 511 -> 507-byte fragments
    pushFrags(600, 200, 8'h11, 8'h22, 0);
    runMsg(600, 200, 8'h11, 8'h22);
    chk(lastOk && genCnt == 2, "R2 capped fragments", genCnt, 2);
    @(negedge clk);

    // R2 depth too small: every attempt fails, nothing written
    runMsg(10, 1, 1, 1);
    chk(!lastOk && wrCnt == 0, "R2 zero limit fails", wrCnt, 0);
    @(negedge clk);

    // R4 slot waits
    emptySlots = 8'd0;
    pushFrags(5, 8, 4, 5, 0);
    fork
      runMsg(5, 8, 4, 5);
      begin
        repeat (30) @(negedge clk);
        chk(wrCnt == 0, "R4 no header without room", wrCnt, 0);
        emptySlots = 8'd1;
        repeat (30) @(negedge clk);
        chk(wrCnt == 1, "R4 payload waits for 2 slots", wrCnt, 1);
        emptySlots = 8'd2;
      end
    join
    chk(lastOk, "R4 completes", lastOk, 1);
    emptySlots = 8'd255;
    @(negedge clk);

    // R6 R9 peer drops ready after first fragment -> resend from byte 0
    pushFrags(40, 8, 9, 10, 1);
    pushFrags(40, 8, 9, 10, 0);
    fork
      runMsg(40, 8, 9, 10);
      begin
        while (!intGen) @(negedge clk);
        peerReady = 1'b0;
        repeat (10) @(negedge clk);
        peerReady = 1'b1;
      end
    join
    chk(lastOk, "R9 retry succeeds", lastOk, 1);
    chk(genCnt == 3, "R6 rings incl failed", genCnt, 3);
    chk(clrCnt == 1, "R8 no clear on retry", clrCnt, 1);
    @(negedge clk);

    // R9 R10 peer never ready: five timed-out attempts
    peerReady = 1'b0;
    runMsg(8, 8, 1, 2);
    chk(!lastOk, "R9 gives up", lastOk, 0);
    chk(lastCyc >= 5 * TMO && lastCyc <= 5 * TMO + 20, "R10 timeout length", lastCyc, 5 * TMO);
    chk(wrCnt == 0, "R9 no writes", wrCnt, 0);
    peerReady = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule